// File: doc/BRIEF.md
# Secure Boot Mode Controller

This block decides, once per reset, how much of the chip is open to the outside world. It reads two non-volatile security configuration bytes, a backdoor-key enable bit and an external boot request pin. On the first clock edge after reset is released, it stores a boot policy. The policy has four parts: a boot mode (internal, external or secure), the start address for instruction fetch, a gate that allows external program-space accesses, and a gate that allows the debug port to read internal memory. The stored policy stays fixed until the next reset. Because it is rebuilt from the non-volatile bytes at every reset, a secured device stays secured through resets and power cycles.

The device is open only when both configuration bytes hold the unsecure pattern, which is all zeros by default. Any other value, including an erased array, secures the device. A secured device always boots from on-chip memory at the internal boot address and ignores the external boot pin. Both access gates stay closed. Firmware may run a backdoor key check, which is outside this block. If that check passes, firmware pulses `unlock_pulse`. The pulse reopens both gates until the next reset, but only if the key-enable bit was set when the policy was stored. Apart from these gates, program execution is unaffected.

Top module: `secure_boot_ctrl`

## Requirements
- R1: While reset is held, and before the first post-reset edge has stored the policy, the block reports the most restrictive state: `boot_mode` = 2'b10 (secure), `boot_addr` = 0x020000, and both access gates low.
- R2: The device counts as secured unless both configuration bytes equal 8'h00. These values are sampled at the first rising clock edge at which `rst_n` is high.
- R3: When secured, `boot_mode` = 2'b10 and `boot_addr` = 0x020000, whatever the level of `ext_boot_req`.
- R4: When secured and not unlocked, `ext_pspace_en` and `dbg_read_en` are both 0.
- R5: When unsecured with `ext_boot_req` = 0, `boot_mode` = 2'b00 (internal), `boot_addr` = 0x020000, and both gates are 1.
- R6: When unsecured with `ext_boot_req` = 1, `boot_mode` = 2'b01 (external), `boot_addr` = 0x000000, and both gates are 1.
- R7: Once stored, the mode, address and security state do not change until the next reset, whatever later happens on the configuration bytes or the boot pin.
- R8: On a secured device whose stored key-enable bit is 1, `unlock_pulse` high at a clock edge after the policy is stored raises both gates from that edge onward. The gates stay high until reset, and the mode and address do not change.
- R9: If the stored key-enable bit is 0, `unlock_pulse` has no effect on the gates.
- R10: `unlock_pulse` is ignored during reset and at the edge that stores the policy.
- R11: A new reset samples the inputs again and clears any earlier unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_byte_lo | input | 8 | First security configuration byte from flash |
| cfg_byte_hi | input | 8 | Second security configuration byte from flash |
| key_enable | input | 1 | Backdoor key access allowed |
| ext_boot_req | input | 1 | External boot request pin |
| unlock_pulse | input | 1 | Firmware signal that the key comparison passed |
| boot_mode | output | 2 | 00 internal, 01 external, 10 secure |
| boot_addr | output | 21 | Start address for instruction fetch |
| ext_pspace_en | output | 1 | External program-space access allowed |
| dbg_read_en | output | 1 | Debug-port memory read allowed |

## Verification
Storing the policy and accepting an unlock pulse can fall in the same cycle. That happens when firmware, or a glitch, holds `unlock_pulse` high at the very edge where reset is released. The bench provokes this on a secured, key-enabled device by raising `unlock_pulse` together with `rst_n`. It then expects both gates to stay closed in the following cycles. A later pulse must open the gates, which shows that the first pulse was ignored because of its timing and not because the key was disabled. The bench also holds the pulse high while reset is asserted and checks that the gates are still closed after release.

// File: rtl/sbm_pkg.sv
// Shared definitions for the secure boot mode controller.
// Assumes the boot mode encoding is decoded by neighbouring logic as-is.
package sbm_pkg;
    typedef enum logic [1:0] {
        BOOT_INTERNAL = 2'b00,
        BOOT_EXTERNAL = 2'b01,
        BOOT_SECURE   = 2'b10
    } boot_mode_e;
endpackage

// File: rtl/sbm_cfg_decode.sv
// Decides from the non-volatile configuration bytes whether the device is
// locked. Only the exact open pattern unlocks; every other value locks.
// Assumes the bytes are stable around the edge that ends reset.
module sbm_cfg_decode #(
    parameter int              CFG_W   = 8,
    parameter logic [CFG_W-1:0] OPEN_LO = '0,
    parameter logic [CFG_W-1:0] OPEN_HI = '0
) (
    input  logic [CFG_W-1:0] cfg_lo,
    input  logic [CFG_W-1:0] cfg_hi,
    output logic             lock_req
);
    localparam int NBYTE = 2;
    logic [NBYTE-1:0] match;
    logic [CFG_W-1:0] bytes_in [NBYTE];
    logic [CFG_W-1:0] pattern  [NBYTE];

    // Collect the bytes and their open patterns for the per-byte compare.
    always_comb begin
        bytes_in[0] = cfg_lo;
        bytes_in[1] = cfg_hi;
        pattern[0]  = OPEN_LO;
        pattern[1]  = OPEN_HI;
    end

    for (genvar g = 0; g < NBYTE; g++) begin : g_cmp
        // Compare one byte against its open pattern.
        always_comb match[g] = (bytes_in[g] == pattern[g]);
    end

    // Lock unless every byte matches the open pattern.
    always_comb lock_req = ~(&match);
endmodule

// File: rtl/sbm_policy_latch.sv
// Stores the boot policy at the first clock edge after reset is released
// and holds it until the next reset. Before that edge it reports the
// secure defaults. Assumes a synchronous active-low reset.
module sbm_policy_latch
    import sbm_pkg::*;
#(
    parameter int                ADDR_W   = 21,
    parameter logic [ADDR_W-1:0] INT_ADDR = 21'h020000,
    parameter logic [ADDR_W-1:0] EXT_ADDR = 21'h000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_req,
    input  logic              key_en,
    input  logic              ext_req,
    output logic              armed,
    output logic              locked_q,
    output logic              key_ok_q,
    output boot_mode_e        mode_q,
    output logic [ADDR_W-1:0] addr_q
);
    boot_mode_e        mode_d;
    logic [ADDR_W-1:0] addr_d;

    // Choose mode and address; a locked device never honours the pin.
    always_comb begin
        if (lock_req) begin
            mode_d = BOOT_SECURE;
            addr_d = INT_ADDR;
        end else if (ext_req) begin
            mode_d = BOOT_EXTERNAL;
            addr_d = EXT_ADDR;
        end else begin
            mode_d = BOOT_INTERNAL;
            addr_d = INT_ADDR;
        end
    end

    // Capture the policy once per reset, then hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            locked_q <= 1'b1;
            key_ok_q <= 1'b0;
            mode_q   <= BOOT_SECURE;
            addr_q   <= INT_ADDR;
        end else if (!armed) begin
            armed    <= 1'b1;
            locked_q <= lock_req;
            key_ok_q <= key_en;
            mode_q   <= mode_d;
            addr_q   <= addr_d;
        end
    end

    // R7
    policy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(armed) |-> ($stable(mode_q) && $stable(addr_q) && $stable(locked_q)));

    // R3
    secure_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && locked_q) |-> (mode_q == BOOT_SECURE && addr_q == INT_ADDR));

    // R6
    ext_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BOOT_EXTERNAL) |-> (addr_q == EXT_ADDR && !locked_q));
endmodule

// File: rtl/sbm_unlock_gate.sv
// Drives the external program-space gate and the debug read gate. A
// locked device keeps both closed unless a backdoor unlock arrives after
// the policy is stored and the stored key-enable bit allows it.
module sbm_unlock_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic locked_q,
    input  logic key_ok_q,
    input  logic unlock_pulse,
    output logic ext_en,
    output logic dbg_en
);
    logic open_q;
    logic grant;

    // An unlock counts only on a stored, locked, key-enabled policy.
    always_comb grant = armed && locked_q && key_ok_q && unlock_pulse;

    // Remember a granted unlock until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_q | grant;
    end

    // Gates open once the policy is stored and the device is open or unlocked.
    always_comb begin
        ext_en = armed && (!locked_q || open_q);
        dbg_en = armed && (!locked_q || open_q);
    end

    // R10
    no_early_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> !open_q);

    // R9
    key_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !key_ok_q) |-> !open_q);

    // R8
    open_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |=> open_q);

    // R4
    locked_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !open_q) |-> (!ext_en && !dbg_en));
endmodule

// File: rtl/secure_boot_ctrl.sv
// Top level of the secure boot mode controller. It decodes the security
// bytes, stores the boot policy once per reset and drives the access gates.
// Assumes the configuration bytes, key enable and boot pin are valid while
// reset is held.
module secure_boot_ctrl #(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_byte_lo,
    input  logic [7:0]        cfg_byte_hi,
    input  logic              key_enable,
    input  logic              ext_boot_req,
    input  logic              unlock_pulse,
    output logic [1:0]        boot_mode,
    output logic [ADDR_W-1:0] boot_addr,
    output logic              ext_pspace_en,
    output logic              dbg_read_en
);
    import sbm_pkg::*;

    localparam logic [ADDR_W-1:0] INT_BOOT = ADDR_W'(32'h0002_0000);
    localparam logic [ADDR_W-1:0] EXT_BOOT = '0;

    logic       lock_req;
    logic       armed;
    logic       locked_q;
    logic       key_ok_q;
    boot_mode_e mode_q;

    sbm_cfg_decode #(.CFG_W(8), .OPEN_LO(8'h00), .OPEN_HI(8'h00)) u_decode (
        .cfg_lo   (cfg_byte_lo),
        .cfg_hi   (cfg_byte_hi),
        .lock_req (lock_req)
    );

    sbm_policy_latch #(.ADDR_W(ADDR_W), .INT_ADDR(INT_BOOT), .EXT_ADDR(EXT_BOOT)) u_policy (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_req (lock_req),
        .key_en   (key_enable),
        .ext_req  (ext_boot_req),
        .armed    (armed),
        .locked_q (locked_q),
        .key_ok_q (key_ok_q),
        .mode_q   (mode_q),
        .addr_q   (boot_addr)
    );

    sbm_unlock_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .armed        (armed),
        .locked_q     (locked_q),
        .key_ok_q     (key_ok_q),
        .unlock_pulse (unlock_pulse),
        .ext_en       (ext_pspace_en),
        .dbg_en       (dbg_read_en)
    );

    // Present the stored mode as a plain bit vector.
    always_comb boot_mode = mode_q;

    // R1
    reset_secure_chk: assert property (@(posedge clk)
        !rst_n |=> (boot_mode == 2'b10 && !ext_pspace_en && !dbg_read_en));

    // R8
    unlock_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(armed) && $rose(ext_pspace_en)) |-> ($stable(boot_mode) && $past(unlock_pulse)));
endmodule

// File: tb/secure_boot_ctrl_test.sv
module secure_boot_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam logic [20:0] INT_A = 21'h020000;
    localparam logic [20:0] EXT_A = 21'h000000;

    // Layout: lo[22:15] hi[14:7] key[6] pin[5] pulse[4] mode[3:2] gate[1] gate_after_pulse[0]
    localparam logic [22:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1},
        {8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1},
        {8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0},
        {8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0},
        {8'h00, 8'h01, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1},
        {8'h80, 8'h00, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0},
        {8'hA5, 8'h5A, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 2'b01, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  lo = 8'hFF;
    logic [7:0]  hi = 8'hFF;
    logic        key = 1'b0;
    logic        pin = 1'b0;
    logic        pulse = 1'b0;
    logic [1:0]  mode;
    logic [20:0] addr;
    logic        ext_en;
    logic        dbg_en;
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secure_boot_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_byte_lo(lo), .cfg_byte_hi(hi),
        .key_enable(key), .ext_boot_req(pin), .unlock_pulse(pulse),
        .boot_mode(mode), .boot_addr(addr), .ext_pspace_en(ext_en), .dbg_read_en(dbg_en)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_gates(input string req, input logic exp);
        check(req, "ext_pspace_en", 32'(ext_en), 32'(exp));
        check(req, "dbg_read_en", 32'(dbg_en), 32'(exp));
    endtask

    // Hold reset with given inputs, check the reset state (R1), then release.
    task automatic reset_into(input logic [7:0] b0, input logic [7:0] b1, input logic k,
                              input logic p, input logic pulse_at_release);
        @(negedge clk);
        rst_n = 1'b0; lo = b0; hi = b1; key = k; pin = p; pulse = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "mode in reset", 32'(mode), 32'h2);
        check("R1", "addr in reset", 32'(addr), 32'(INT_A));
        check_gates("R1", 1'b0);
        rst_n = 1'b1;
        pulse = pulse_at_release;
        @(negedge clk);
        pulse = 1'b0;
    endtask

    task automatic give_pulse();
        pulse = 1'b1;
        @(negedge clk);
        pulse = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // Vector table: R2 to R6, plus R8 and R9 through the pulse column
        for (int i = 0; i < NVEC; i++) begin
            logic [22:0] v;
            logic [1:0]  em;
            string       tag;
            v  = VEC[i];
            em = v[3:2];
            tag = (em == 2'b10) ? "R2 R3 R4" : ((em == 2'b01) ? "R2 R6" : "R2 R5");
            reset_into(v[22:15], v[14:7], v[6], v[5], 1'b0);
            check(tag, "boot_mode", 32'(mode), 32'(em));
            check(tag, "boot_addr", 32'(addr), 32'((em == 2'b01) ? EXT_A : INT_A));
            check_gates(tag, v[1]);
            if (v[4]) begin
                give_pulse();
                tag = v[6] ? "R8" : "R9";
                check_gates(tag, v[0]);
                check(tag, "mode after pulse", 32'(mode), 32'(em));
                check(tag, "addr after pulse", 32'(addr), 32'((em == 2'b01) ? EXT_A : INT_A));
            end
        end

        // R7: inputs change after the policy is stored; nothing may move
        reset_into(8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        lo = 8'hFF; hi = 8'h3C; pin = 1'b1;
        repeat (3) @(negedge clk);
        check("R7", "mode held", 32'(mode), 32'h0);
        check("R7", "addr held", 32'(addr), 32'(INT_A));
        check_gates("R7", 1'b1);

        // R10: pulse at the edge that stores the policy is ignored
        reset_into(8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1);
        check_gates("R10", 1'b0);
        @(negedge clk);
        check_gates("R10", 1'b0);
        give_pulse();
        check_gates("R8", 1'b1);
        repeat (2) @(negedge clk);
        check_gates("R8", 1'b1);
        check("R8", "mode after unlock", 32'(mode), 32'h2);

        // R11: reset clears the earlier unlock
        reset_into(8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0);
        check_gates("R11", 1'b0);

        // R10: pulse held during reset is ignored
        @(negedge clk);
        rst_n = 1'b0; pulse = 1'b1;
        repeat (2) @(negedge clk);
        pulse = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_gates("R10", 1'b0);

        // R11: new bytes at reset give a new policy
        reset_into(8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R11", "mode resampled", 32'(mode), 32'h1);
        check_gates("R11", 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule